// File: doc/BRIEF.md
# Floating-Point Register File with Switchable Aliasing

This block holds the floating-point operand storage of a processor core: 32 entries of 64 bits, reached through one single-precision (32-bit) read port, one double-precision (64-bit) read port, one single-precision write port and one double-precision write port. A mode input selects how a register number reaches storage. In paired mode, odd and even singles share one 64-bit entry and a double number is rounded down to the even entry. In flat mode, every number owns a whole entry, and a single uses the low half of it. The mode is taken from the input in the cycle of each access, so changing it changes the aliasing of the very next access.

Beside the data storage, the block holds a small control-register space. Index 0 returns a fixed revision word. Index 31 is the status/control word, which holds flags, exception enables and exception causes. A write to index 31 stores the word with its reserved bits cleared, and raises a one-cycle exception request if any enabled cause is present or if the unimplemented-operation cause is set. The arithmetic that produces the cause bits is outside this block.

All read data and the exception request come from registers and appear one clock after the request. A read returns the storage contents from before any write made in the same cycle.

Top module: `fpu_regfile_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all read outputs and `exc_req` are zero. The reset clears every storage entry and the status word.
- R2: In paired mode (`mode_flat`=0), single register n is bits [31:0] of entry (n with bit 0 cleared) when n is even, and bits [63:32] of that entry when n is odd.
- R3: In paired mode, double register n reads and writes the whole entry (n with bit 0 cleared), so double n and double n+1 alias each other for every even n.
- R4: In flat mode (`mode_flat`=1), single register n is bits [31:0] of entry n and double register n is all of entry n.
- R5: A single write changes only the addressed 32-bit half. The other half of that entry keeps its value.
- R6: Every read output shows its data in the cycle after the request. A read and a write to the same location in the same cycle return the value from before the write.
- R7: If a single write and a double write hit the same entry in the same cycle, the half addressed by the single write takes the single data, and the other half takes the matching half of the double data.
- R8: A write to control index 31 stores the data ANDed with 0x0183FFFF, and a later read of index 31 returns that value.
- R9: Enables sit in bits 11:7 and causes in bits 16:12, each ordered inexact, underflow, overflow, divide-by-zero, invalid from the low bit up (flags occupy bits 6:2). After a write to index 31, `exc_req` is 1 in the next cycle if any cause bit and its matching enable bit are both set in the stored value.
- R10: After a write to index 31 whose stored value has bit 17 (unimplemented operation) set, `exc_req` is 1 in the next cycle, whatever the enables are. `exc_req` is 0 in every cycle that does not follow such a triggering write.
- R11: A read of control index 0 returns 0x00000A00. Reads of indices 1 to 30 return zero. Writes to any control index other than 31 do not change anything that can be read.
- R12: The mapping follows the value of `mode_flat` in the cycle of each access, so the same number can reach different storage in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_flat | input | 1 | 0 = paired aliasing, 1 = flat aliasing |
| s_rd_idx | input | 5 | Single-precision read register number |
| s_rd_data | output | 32 | Single-precision read data, one cycle later |
| d_rd_idx | input | 5 | Double-precision read register number |
| d_rd_data | output | 64 | Double-precision read data, one cycle later |
| s_wr_en | input | 1 | Single-precision write strobe |
| s_wr_idx | input | 5 | Single-precision write register number |
| s_wr_data | input | 32 | Single-precision write data |
| d_wr_en | input | 1 | Double-precision write strobe |
| d_wr_idx | input | 5 | Double-precision write register number |
| d_wr_data | input | 64 | Double-precision write data |
| c_wr_en | input | 1 | Control register write strobe |
| c_wr_idx | input | 5 | Control register write index |
| c_wr_data | input | 32 | Control register write data |
| c_rd_idx | input | 5 | Control register read index |
| c_rd_data | output | 32 | Control register read data, one cycle later |
| exc_req | output | 1 | One-cycle exception request after a triggering status write |

## Verification
Two things can fall in the same cycle: a single-precision write and a double-precision write that land in one 64-bit entry, and a read of a location while it is being written. The bench forces both on purpose. It writes an odd single and its even double together in paired mode, and it reads the same number it writes. It also lets the random phase hit them with small index ranges and a toggling mode bit. A behavioural model applies the double write first, lets the single write override its half, and keeps its expected read data from before the cycle's writes. Every read port is compared against that model on every clock.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic {
    MODE_PAIRED = 1'b0,
    MODE_FLAT   = 1'b1
  } fpr_mode_e;

  localparam int CTRL_W       = 32;
  localparam logic [CTRL_W-1:0] CSR_WR_MASK = 32'h0183_FFFF;
  localparam logic [CTRL_W-1:0] REVISION    = 32'h0000_0A00;

  // status word layout: five exception kinds, low bit = inexact
  localparam int N_EXC        = 5;
  localparam int FLAG_LSB     = 2;
  localparam int ENABLE_LSB   = 7;
  localparam int CAUSE_LSB    = 12;
  localparam int CAUSE_UNIMPL = 17;

endpackage

// File: rtl/fpr_idx_map.sv
module fpr_idx_map
  import fpr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  fpr_mode_e        mode,
  input  logic [IDX_W-1:0] s_idx,
  input  logic [IDX_W-1:0] d_idx,
  output logic [IDX_W-1:0] s_entry,
  output logic             s_hi,
  output logic [IDX_W-1:0] d_entry
);

  always_comb begin
    if (mode == MODE_FLAT) begin
      s_entry = s_idx;
      s_hi    = 1'b0;
      d_entry = d_idx;
    end else begin
      s_entry = {s_idx[IDX_W-1:1], 1'b0};
      s_hi    = s_idx[0];
      d_entry = {d_idx[IDX_W-1:1], 1'b0};
    end
  end

endmodule

// File: rtl/fpr_storage.sv
module fpr_storage #(
  parameter int N_ENT  = 32,
  parameter int HALF_W = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_wr_en,
  input  logic [IDX_W-1:0]    s_wr_entry,
  input  logic                s_wr_hi,
  input  logic [HALF_W-1:0]   s_wr_data,
  input  logic                d_wr_en,
  input  logic [IDX_W-1:0]    d_wr_entry,
  input  logic [2*HALF_W-1:0] d_wr_data,
  input  logic [IDX_W-1:0]    s_rd_entry,
  input  logic                s_rd_hi,
  input  logic [IDX_W-1:0]    d_rd_entry,
  output logic [HALF_W-1:0]   s_rd_q,
  output logic [2*HALF_W-1:0] d_rd_q
);

  logic [HALF_W-1:0] lo_q [N_ENT];
  logic [HALF_W-1:0] hi_q [N_ENT];

  // one write slot per half per entry; the single write overrides its half
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic s_hit_lo, s_hit_hi, d_hit;
    assign s_hit_lo = s_wr_en && (s_wr_entry == IDX_W'(e)) && !s_wr_hi;
    assign s_hit_hi = s_wr_en && (s_wr_entry == IDX_W'(e)) &&  s_wr_hi;
    assign d_hit    = d_wr_en && (d_wr_entry == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[e] <= '0;
        hi_q[e] <= '0;
      end else begin
        if (s_hit_lo)   lo_q[e] <= s_wr_data;
        else if (d_hit) lo_q[e] <= d_wr_data[HALF_W-1:0];
        if (s_hit_hi)   hi_q[e] <= s_wr_data;
        else if (d_hit) hi_q[e] <= d_wr_data[2*HALF_W-1:HALF_W];
      end
    end
  end

  // registered reads see contents before this cycle's writes
  always_ff @(posedge clk) begin
    if (rst) begin
      s_rd_q <= '0;
      d_rd_q <= '0;
    end else begin
      s_rd_q <= s_rd_hi ? hi_q[s_rd_entry] : lo_q[s_rd_entry];
      d_rd_q <= {hi_q[d_rd_entry], lo_q[d_rd_entry]};
    end
  end

  // R5: a lone low-half single write leaves the upper half untouched
  a_r5_other_half_kept: assert property (@(posedge clk) disable iff (rst)
    (s_wr_en && !s_wr_hi && !d_wr_en) |=>
      (hi_q[$past(s_wr_entry)] == $past(hi_q[s_wr_entry])));

  // R7: single write wins its half on a same-entry collision
  a_r7_single_wins: assert property (@(posedge clk) disable iff (rst)
    (s_wr_en && d_wr_en && (s_wr_entry == d_wr_entry) && s_wr_hi) |=>
      (hi_q[$past(s_wr_entry)] == $past(s_wr_data)));

endmodule

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
  import fpr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CTRL_W-1:0] rd_data,
  output logic              exc_req
);

  localparam logic [IDX_W-1:0] IDX_REV  = '0;
  localparam logic [IDX_W-1:0] IDX_CSR  = '1;

  logic [CTRL_W-1:0] csr_q;
  logic [CTRL_W-1:0] csr_next;
  logic [N_EXC-1:0]  armed;
  logic              csr_wr;
  logic              trigger;

  assign csr_wr   = wr_en && (wr_idx == IDX_CSR);
  assign csr_next = wr_data & CSR_WR_MASK;
  assign armed    = csr_next[CAUSE_LSB +: N_EXC] & csr_next[ENABLE_LSB +: N_EXC];
  assign trigger  = csr_wr && ((|armed) || csr_next[CAUSE_UNIMPL]);

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q   <= '0;
      rd_data <= '0;
      exc_req <= 1'b0;
    end else begin
      if (csr_wr) csr_q <= csr_next;
      exc_req <= trigger;
      if (rd_idx == IDX_REV)      rd_data <= REVISION;
      else if (rd_idx == IDX_CSR) rd_data <= csr_q;
      else                        rd_data <= '0;
    end
  end

  // R8: reserved status bits never hold a one
  a_r8_reserved_clear: assert property (@(posedge clk) disable iff (rst)
    (csr_q & ~CSR_WR_MASK) == '0);

  // R10: request only follows a write to the status index
  a_r10_req_needs_write: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> $past(wr_en && (wr_idx == IDX_CSR)));

  // R10: unimplemented cause always raises the request
  a_r10_unimpl_raises: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == IDX_CSR) && wr_data[CAUSE_UNIMPL]) |=> exc_req);

  // R11: revision index reads its fixed word
  a_r11_revision: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_idx == IDX_REV)) |-> (rd_data == REVISION));

endmodule

// File: rtl/fpu_regfile_top.sv
module fpu_regfile_top
  import fpr_pkg::*;
#(
  parameter int N_REGS = 32,
  parameter int HALF_W = 32,
  localparam int IDX_W = $clog2(N_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_flat,
  input  logic [IDX_W-1:0]    s_rd_idx,
  output logic [HALF_W-1:0]   s_rd_data,
  input  logic [IDX_W-1:0]    d_rd_idx,
  output logic [2*HALF_W-1:0] d_rd_data,
  input  logic                s_wr_en,
  input  logic [IDX_W-1:0]    s_wr_idx,
  input  logic [HALF_W-1:0]   s_wr_data,
  input  logic                d_wr_en,
  input  logic [IDX_W-1:0]    d_wr_idx,
  input  logic [2*HALF_W-1:0] d_wr_data,
  input  logic                c_wr_en,
  input  logic [IDX_W-1:0]    c_wr_idx,
  input  logic [CTRL_W-1:0]   c_wr_data,
  input  logic [IDX_W-1:0]    c_rd_idx,
  output logic [CTRL_W-1:0]   c_rd_data,
  output logic                exc_req
);

  localparam int N_PAIRS = 2;  // 0 = read pair, 1 = write pair

  fpr_mode_e        mode;
  logic [IDX_W-1:0] m_s_idx   [N_PAIRS];
  logic [IDX_W-1:0] m_d_idx   [N_PAIRS];
  logic [IDX_W-1:0] m_s_entry [N_PAIRS];
  logic             m_s_hi    [N_PAIRS];
  logic [IDX_W-1:0] m_d_entry [N_PAIRS];

  assign mode       = fpr_mode_e'(mode_flat);
  assign m_s_idx[0] = s_rd_idx;
  assign m_d_idx[0] = d_rd_idx;
  assign m_s_idx[1] = s_wr_idx;
  assign m_d_idx[1] = d_wr_idx;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_map
    fpr_idx_map #(.IDX_W(IDX_W)) u_map (
      .mode    (mode),
      .s_idx   (m_s_idx[p]),
      .d_idx   (m_d_idx[p]),
      .s_entry (m_s_entry[p]),
      .s_hi    (m_s_hi[p]),
      .d_entry (m_d_entry[p])
    );
  end

  fpr_storage #(.N_ENT(N_REGS), .HALF_W(HALF_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .s_wr_en    (s_wr_en),
    .s_wr_entry (m_s_entry[1]),
    .s_wr_hi    (m_s_hi[1]),
    .s_wr_data  (s_wr_data),
    .d_wr_en    (d_wr_en),
    .d_wr_entry (m_d_entry[1]),
    .d_wr_data  (d_wr_data),
    .s_rd_entry (m_s_entry[0]),
    .s_rd_hi    (m_s_hi[0]),
    .d_rd_entry (m_d_entry[0]),
    .s_rd_q     (s_rd_data),
    .d_rd_q     (d_rd_data)
  );

  fpr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (c_wr_en),
    .wr_idx  (c_wr_idx),
    .wr_data (c_wr_data),
    .rd_idx  (c_rd_idx),
    .rd_data (c_rd_data),
    .exc_req (exc_req)
  );

  // R3: in paired mode an odd double reads the same entry as its even partner
  a_r3_double_alias: assert property (@(posedge clk) disable iff (rst)
    (!mode_flat && d_rd_idx[0]) |-> (m_d_entry[0] == (d_rd_idx ^ IDX_W'(1))));

endmodule

// File: tb/sim_fpu_regfile_top.sv
module sim_fpu_regfile_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_flat = 1'b0;
  logic [4:0]  s_rd_idx = '0, d_rd_idx = '0, s_wr_idx = '0, d_wr_idx = '0;
  logic [4:0]  c_wr_idx = '0, c_rd_idx = '0;
  logic        s_wr_en = 1'b0, d_wr_en = 1'b0, c_wr_en = 1'b0;
  logic [31:0] s_wr_data = '0, c_wr_data = '0;
  logic [63:0] d_wr_data = '0;
  logic [31:0] s_rd_data, c_rd_data;
  logic [63:0] d_rd_data;
  logic        exc_req;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  logic [63:0] mem [32];
  logic [31:0] m_csr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_regfile_top u0 (
    .clk(clk), .rst(rst), .mode_flat(mode_flat),
    .s_rd_idx(s_rd_idx), .s_rd_data(s_rd_data),
    .d_rd_idx(d_rd_idx), .d_rd_data(d_rd_data),
    .s_wr_en(s_wr_en), .s_wr_idx(s_wr_idx), .s_wr_data(s_wr_data),
    .d_wr_en(d_wr_en), .d_wr_idx(d_wr_idx), .d_wr_data(d_wr_data),
    .c_wr_en(c_wr_en), .c_wr_idx(c_wr_idx), .c_wr_data(c_wr_data),
    .c_rd_idx(c_rd_idx), .c_rd_data(c_rd_data), .exc_req(exc_req)
  );

  function automatic int ent_of(input int n, input logic flat);
    return flat ? n : (n / 2) * 2;
  endfunction

  function automatic int half_of(input int n, input logic flat);
    return flat ? 0 : n % 2;
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: predict from model, update model, compare after the edge
  task automatic step();
    logic [31:0] e_s, e_c, v;
    logic [63:0] e_d, cur;
    logic        e_x;
    int          se, de;
    if (rst) begin
      e_s = '0; e_d = '0; e_c = '0; e_x = 1'b0;
      foreach (mem[i]) mem[i] = '0;
      m_csr = '0;
    end else begin
      se  = ent_of(int'(s_rd_idx), mode_flat);
      e_s = half_of(int'(s_rd_idx), mode_flat) == 1 ? mem[se][63:32] : mem[se][31:0];
      e_d = mem[ent_of(int'(d_rd_idx), mode_flat)];
      e_c = (c_rd_idx == 5'd0) ? 32'h0000_0A00 : (c_rd_idx == 5'd31) ? m_csr : 32'h0;
      e_x = 1'b0;
      if (d_wr_en) mem[ent_of(int'(d_wr_idx), mode_flat)] = d_wr_data;
      if (s_wr_en) begin
        de  = ent_of(int'(s_wr_idx), mode_flat);
        cur = mem[de];
        if (half_of(int'(s_wr_idx), mode_flat) == 1) cur[63:32] = s_wr_data;
        else cur[31:0] = s_wr_data;
        mem[de] = cur;
      end
      if (c_wr_en && c_wr_idx == 5'd31) begin
        v = c_wr_data & 32'h0183_FFFF;
        m_csr = v;
        e_x = ((v[16:12] & v[11:7]) != 5'b0) || v[17];
      end
    end
    @(posedge clk);
    #1;
    chk("s_rd_data", {32'h0, s_rd_data}, {32'h0, e_s});
    chk("d_rd_data", d_rd_data, e_d);
    chk("c_rd_data", {32'h0, c_rd_data}, {32'h0, e_c});
    chk("exc_req", {63'h0, exc_req}, {63'h0, e_x});
  endtask

  task automatic idle();
    s_wr_en = 1'b0; d_wr_en = 1'b0; c_wr_en = 1'b0;
  endtask

  task automatic swr(input int n, input logic [31:0] v);
    s_wr_en = 1'b1; s_wr_idx = 5'(n); s_wr_data = v;
  endtask

  task automatic dwr(input int n, input logic [63:0] v);
    d_wr_en = 1'b1; d_wr_idx = 5'(n); d_wr_data = v;
  endtask

  task automatic cwr(input int n, input logic [31:0] v);
    c_wr_en = 1'b1; c_wr_idx = 5'(n); c_wr_data = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: reset state, including a status read
    tag = "R1"; c_rd_idx = 5'd31;
    step(); step();
    rst = 1'b0; step();

    // R2 / R3: paired mode aliasing
    tag = "R2"; mode_flat = 1'b0;
    swr(4, 32'hAAAA_0004); step();
    swr(5, 32'hBBBB_0005); step();
    idle(); s_rd_idx = 5'd5; d_rd_idx = 5'd4; step(); step();
    tag = "R3"; d_rd_idx = 5'd5; dwr(9, 64'h1111_2222_3333_4444); step();
    idle(); d_rd_idx = 5'd8; s_rd_idx = 5'd9; step(); step();

    // R4: flat mode
    tag = "R4"; mode_flat = 1'b1;
    dwr(6, 64'hCAFE_F00D_DEAD_BEEF); step();
    idle(); swr(7, 32'h7777_7777); s_rd_idx = 5'd6; step();
    idle(); d_rd_idx = 5'd7; s_rd_idx = 5'd7; step(); step();

    // R5: single write keeps the other half
    tag = "R5"; mode_flat = 1'b0;
    dwr(10, 64'hFFFF_FFFF_FFFF_FFFF); step();
    idle(); swr(11, 32'h0000_1234); step();
    idle(); swr(10, 32'h0000_5678); step();
    idle(); d_rd_idx = 5'd10; step(); step();

    // R6: read and write to the same place in one cycle
    tag = "R6"; s_rd_idx = 5'd20; swr(20, 32'h2020_2020); step();
    idle(); step(); step();

    // R7: same-entry collision of single and double writes
    tag = "R7"; dwr(12, 64'h0D0D_0D0D_D0D0_D0D0); swr(13, 32'h5151_5151); step();
    idle(); d_rd_idx = 5'd12; step(); step();
    mode_flat = 1'b1; dwr(14, 64'hABCD_ABCD_1234_1234); swr(14, 32'h9999_0000); step();
    idle(); d_rd_idx = 5'd14; step(); step();

    // R8 / R10: all ones, masked, unimplemented cause
    tag = "R8"; c_rd_idx = 5'd31; cwr(31, 32'hFFFF_FFFF); step();
    idle(); step(); step();
    // R9: overflow cause with overflow enable, then with a mismatched enable
    tag = "R9"; cwr(31, 32'h0000_4200); step();
    cwr(31, 32'h0000_4100); step();
    idle(); step();
    // R10: unimplemented with no enables, then request drops
    tag = "R10"; cwr(31, 32'h0002_0000); step();
    idle(); step(); step();
    // R11: revision, undefined indices, ignored writes
    tag = "R11"; c_rd_idx = 5'd0; cwr(0, 32'h1234_5678); step();
    cwr(5, 32'hFFFF_FFFF); c_rd_idx = 5'd5; step();
    idle(); step(); c_rd_idx = 5'd0; step(); step();
    c_rd_idx = 5'd31; step(); step();

    // R12: random traffic with a toggling mode bit and narrow indices
    tag = "R12";
    for (int k = 0; k < 4000; k++) begin
      mode_flat = 1'($urandom_range(0, 1));
      s_rd_idx  = 5'($urandom_range(0, 7));
      d_rd_idx  = 5'($urandom_range(0, 7));
      s_wr_en   = 1'($urandom_range(0, 1));
      s_wr_idx  = 5'($urandom_range(0, 7));
      s_wr_data = $urandom;
      d_wr_en   = 1'($urandom_range(0, 1));
      d_wr_idx  = 5'($urandom_range(0, 7));
      d_wr_data = {$urandom, $urandom};
      c_wr_en   = ($urandom_range(0, 3) == 0);
      c_wr_idx  = ($urandom_range(0, 1) == 0) ? 5'd31 : 5'($urandom_range(0, 31));
      c_wr_data = $urandom;
      c_rd_idx  = 5'($urandom_range(0, 31));
      step();
    end
    idle(); step();
    summary();
  end

endmodule